// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Masks

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each accepted operation takes two byte operands: a register value on `src_a`, and a second register value or an immediate on `src_b`. It also takes a 4-bit operation code. The block returns a registered byte result and an updated 8-bit status register. Every operation carries its own mask of status bits that it may write. Bits outside that mask keep their previous value, so a flag survives until an operation that owns it runs.

The status register holds six flags that the ALU can write: carry, zero, negative, overflow, sign and half-carry. The sign flag is the exclusive OR of negative and overflow, and it is recomputed whenever either of them is written. The add-with-carry and subtract-with-carry operations read their carry input from the registered carry flag.

Word operations add an immediate to a 16-bit register pair, or subtract one from it. The pair is formed from `pair_hi` (high byte) and `src_a` (low byte). A single 8-bit adder handles these operations. The low byte is computed in the issue cycle and the high byte in the following cycle, while `busy` is held high.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `status`, `result` and `result_hi` are 0x00, and `done` and `busy` are 0.
- R2: Add (code 0) gives `src_a + src_b`, and add-with-carry (code 1) also adds the status carry bit. Both write H (carry out of bit 3), C (carry out of bit 7), V (signed overflow), N (bit 7 of the result), Z (result is zero) and S.
- R3: Subtract (code 2) gives `src_a - src_b`, and subtract-with-carry (code 3) also subtracts the status carry bit. Negate (code 10) gives `0x00 - src_a`. All three write H (borrow out of bit 3), C (borrow out of bit 7), V, N, Z and S.
- R4: AND (code 4), OR (code 5), XOR (code 6) and clear-bits (code 12, `src_a & ~src_b`) write Z, N and S and force V to 0. H and C keep their previous values.
- R5: Increment (code 7) and decrement (code 8) write Z, N, V and S, and keep H and C. V is 1 only when 0x7F increments to 0x80, or when 0x80 decrements to 0x7F.
- R6: Complement (code 9) gives `0xFF - src_a`. It forces C to 1 and V to 0, writes Z, N and S, and keeps H.
- R7: Set-all (code 11) gives 0xFF, and code 15 passes `src_a` through. Neither changes any status bit.
- R8: Status bit 4 (S) always equals bit 2 (N) XOR bit 3 (V).
- R9: The status bit positions, from bit 7 down to bit 0, are interrupt-enable, transfer bit, H, S, V, N, Z, C. No operation changes bits 7 and 6, which stay 0 after reset.
- R10: Word add (code 13) computes `{pair_hi, src_a} + K`, and word subtract (code 14) computes `{pair_hi, src_a} - K`. K is the low `IMM_W` bits of `src_b`, zero-extended. `busy` is 1 for the one cycle after issue, and `done` is 1 in the cycle after that, with `result` holding the low byte and `result_hi` the high byte. These operations write Z (all 16 bits zero), C (carry or borrow out of bit 15), N (bit 15), V and S. H is kept.
- R11: An `issue` asserted while `busy` is 1 is ignored. The word operation completes unchanged, and the ignored request changes neither the result nor the status.
- R12: A byte operation issued at a clock edge presents `result`, `status` and a one-cycle `done` after that edge, and clears `result_hi` to 0x00. `result` holds its value while no operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Request to run `opcode` on the current operands |
| opcode | input | 4 | Operation code |
| src_a | input | 8 | First operand; the low byte of the pair for word operations |
| src_b | input | 8 | Second operand or immediate; the low `IMM_W` bits form K for word operations |
| pair_hi | input | 8 | High byte of the register pair for word operations |
| result | output | 8 | Byte result, or the low byte of a word result |
| result_hi | output | 8 | High byte of a word result; 0x00 after byte operations |
| done | output | 1 | Result and status updated in this cycle |
| busy | output | 1 | Word operation in its second cycle; new requests are ignored |
| status | output | 8 | Status register |

## Verification
The bench builds the block with the default `IMM_W` of 6. This means a word immediate with bits 7:6 set shows whether those bits are discarded. The stimulus table chains its expected status from one step to the next. As a result, every flag left alone by one operation must still hold the value an earlier operation gave it, and add-with-carry and subtract-with-carry consume a carry produced by an earlier step. The sign and overflow corners at 0x7F/0x80 are exercised for add, subtract, increment, decrement, negate and the 16-bit forms, together with a request raised during the busy cycle.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DW   = 8;
    localparam int HALF = 4;
    localparam int OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_COM  = 4'd9,
        OP_NEG  = 4'd10,
        OP_SER  = 4'd11,
        OP_CBR  = 4'd12,
        OP_WADD = 4'd13,
        OP_WSUB = 4'd14,
        OP_RSV  = 4'd15
    } alu_op_e;

    // status bit positions (bits 7 and 6 are never written here)
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    localparam logic [DW-1:0] MASK_ARITH = 8'h3F; // H S V N Z C
    localparam logic [DW-1:0] MASK_LOGIC = 8'h1E; // S V N Z
    localparam logic [DW-1:0] MASK_CWORD = 8'h1F; // S V N Z C
    localparam logic [DW-1:0] MASK_NONE  = 8'h00;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e          phase;
        logic            wsub;
        logic            wcarry;
        logic [DW-1:0]   hi;
        logic [DW-1:0]   lo;
        logic [DW-1:0]   result;
        logic [DW-1:0]   result_hi;
        logic            done;
        logic [DW-1:0]   status;
    } alu_state_t;

    function automatic logic [DW-1:0] flag_mask(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:         return MASK_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_CBR, OP_INC, OP_DEC:  return MASK_LOGIC;
            OP_COM, OP_WADD, OP_WSUB:                       return MASK_CWORD;
            default:                                        return MASK_NONE;
        endcase
    endfunction

    function automatic logic is_word(alu_op_e op);
        return (op == OP_WADD) || (op == OP_WSUB);
    endfunction

    function automatic logic is_arith(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_INC, OP_DEC, OP_NEG:          return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
    parameter int W    = 8,
    parameter int HBIT = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,   // carry in (add) or borrow in (sub)
    output logic [W-1:0] r,
    output logic         co,    // carry out (add) or borrow out (sub)
    output logic         h,     // carry/borrow out of bit HBIT-1
    output logic         v
);
    logic [W-1:0] bx;
    logic         cin_eff;
    logic [W:0]   full;

    always_comb begin
        bx      = b ^ {W{sub}};
        cin_eff = sub ? ~cin : cin;
        full    = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin_eff};
        r       = full[W-1:0];
        co      = full[W] ^ sub;
        // carry into bit HBIT recovered from the sum bit
        h       = (a[HBIT] ^ bx[HBIT] ^ full[HBIT]) ^ sub;
        v       = (a[W-1] == bx[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);
    always_comb begin
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_CBR:  r = a & ~b;
            OP_COM:  r = ~a;
            OP_SER:  r = {W{1'b1}};
            default: r = a;
        endcase
    end
endmodule

// File: rtl/byte_alu_flagmerge.sv
module byte_alu_flagmerge
    import byte_alu_pkg::*;
(
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] cand,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] nxt
);
    logic [DW-1:0] cand_s;

    always_comb begin
        cand_s       = cand;
        cand_s[FL_S] = cand[FL_N] ^ cand[FL_V];
    end

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign nxt[g] = mask[g] ? cand_s[g] : cur[g];
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int IMM_W = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [3:0]    opcode,
    input  logic [7:0]    src_a,
    input  logic [7:0]    src_b,
    input  logic [7:0]    pair_hi,
    output logic [7:0]    result,
    output logic [7:0]    result_hi,
    output logic          done,
    output logic          busy,
    output logic [7:0]    status
);
    localparam int PAD_W = DW - IMM_W;

    alu_state_t st_q, st_d;
    alu_op_e    op;

    logic [DW-1:0] imm_k;
    logic [DW-1:0] add_a, add_b, add_r;
    logic          add_sub, add_cin, add_co, add_h, add_v;
    logic [DW-1:0] log_r, byte_res;
    logic [DW-1:0] cand, mask, merged;

    assign op    = alu_op_e'(opcode);
    assign imm_k = {{PAD_W{1'b0}}, src_b[IMM_W-1:0]};

    // operand steering for the single shared adder
    always_comb begin
        add_a   = src_a;
        add_b   = src_b;
        add_sub = 1'b0;
        add_cin = 1'b0;
        if (st_q.phase == PH_HIGH) begin
            add_a   = st_q.hi;
            add_b   = '0;
            add_sub = st_q.wsub;
            add_cin = st_q.wcarry;
        end else begin
            case (op)
                OP_ADC:  add_cin = st_q.status[FL_C];
                OP_SUB:  add_sub = 1'b1;
                OP_SBC: begin
                    add_sub = 1'b1;
                    add_cin = st_q.status[FL_C];
                end
                OP_INC:  add_b = 8'd1;
                OP_DEC: begin
                    add_b   = 8'd1;
                    add_sub = 1'b1;
                end
                OP_NEG: begin
                    add_a   = '0;
                    add_b   = src_a;
                    add_sub = 1'b1;
                end
                OP_WADD: add_b = imm_k;
                OP_WSUB: begin
                    add_b   = imm_k;
                    add_sub = 1'b1;
                end
                default: ;
            endcase
        end
    end

    byte_alu_addsub #(.W(DW), .HBIT(HALF)) u_addsub (
        .a   (add_a),
        .b   (add_b),
        .sub (add_sub),
        .cin (add_cin),
        .r   (add_r),
        .co  (add_co),
        .h   (add_h),
        .v   (add_v)
    );

    byte_alu_logic #(.W(DW)) u_logic (
        .op (op),
        .a  (src_a),
        .b  (src_b),
        .r  (log_r)
    );

    // candidate flags and write mask
    always_comb begin
        byte_res = is_arith(op) ? add_r : log_r;
        cand     = '0;
        mask     = MASK_NONE;
        if (st_q.phase == PH_HIGH) begin
            cand[FL_Z] = (add_r == '0) && (st_q.lo == '0);
            cand[FL_N] = add_r[DW-1];
            cand[FL_V] = add_v;
            cand[FL_C] = add_co;
            mask       = MASK_CWORD;
        end else if (issue && !is_word(op)) begin
            cand[FL_Z] = (byte_res == '0);
            cand[FL_N] = byte_res[DW-1];
            cand[FL_V] = is_arith(op) ? add_v : 1'b0;
            cand[FL_C] = (op == OP_COM) ? 1'b1 : add_co;
            cand[FL_H] = add_h;
            mask       = flag_mask(op);
        end
    end

    byte_alu_flagmerge u_merge (
        .cur  (st_q.status),
        .cand (cand),
        .mask (mask),
        .nxt  (merged)
    );

    // next state
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_HIGH) begin
            st_d.phase     = PH_IDLE;
            st_d.result    = st_q.lo;
            st_d.result_hi = add_r;
            st_d.done      = 1'b1;
            st_d.status    = merged;
        end else if (issue) begin
            if (is_word(op)) begin
                st_d.phase  = PH_HIGH;
                st_d.lo     = add_r;
                st_d.hi     = pair_hi;
                st_d.wcarry = add_co;
                st_d.wsub   = (op == OP_WSUB);
            end else begin
                st_d.result    = byte_res;
                st_d.result_hi = '0;
                st_d.done      = 1'b1;
                st_d.status    = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.result;
    assign result_hi = st_q.result_hi;
    assign done      = st_q.done;
    assign busy      = (st_q.phase == PH_HIGH);
    assign status    = st_q.status;

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       issue,
    input logic [3:0] opcode,
    input logic [7:0] result,
    input logic [7:0] result_hi,
    input logic       done,
    input logic       busy,
    input logic [7:0] status
);
    logic go;
    assign go = issue && !busy;

    AST_SIGN_IS_N_XOR_V: assert property (@(posedge clk) disable iff (!rst_n)
        status[FL_S] == (status[FL_N] ^ status[FL_V])); // R8

    AST_TOP_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> $stable(status[7:6])); // R9

    AST_WORD_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (opcode == OP_WADD || opcode == OP_WSUB)) |=> (busy && !done)); // R10

    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done && !busy)); // R11

    AST_SET_ALL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && opcode == OP_SER) |=> ($stable(status) && result == 8'hFF)); // R7

    AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR || opcode == OP_CBR))
        |=> (!status[FL_V] && $stable(status[FL_H]) && $stable(status[FL_C]))); // R4

    AST_STEP_KEEPS_HC: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (opcode == OP_INC || opcode == OP_DEC))
        |=> ($stable(status[FL_H]) && $stable(status[FL_C]))); // R5

    AST_COMPLEMENT_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (go && opcode == OP_COM) |=> (status[FL_C] && !status[FL_V] && $stable(status[FL_H]))); // R6

    AST_BYTE_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !(opcode == OP_WADD || opcode == OP_WSUB)) |=> (done && result_hi == 8'h00)); // R12

endmodule

bind byte_alu byte_alu_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .opcode    (opcode),
    .result    (result),
    .result_hi (result_hi),
    .done      (done),
    .busy      (busy),
    .status    (status)
);

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [7:0] src_a = 8'h00;
    logic [7:0] src_b = 8'h00;
    logic [7:0] pair_hi = 8'h00;
    logic [7:0] result, result_hi, status;
    logic       done, busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk; // 250 MHz

    byte_alu #(.IMM_W(6)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .opcode    (opcode),
        .src_a     (src_a),
        .src_b     (src_b),
        .pair_hi   (pair_hi),
        .result    (result),
        .result_hi (result_hi),
        .done      (done),
        .busy      (busy),
        .status    (status)
    );

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] hi;
        logic [7:0] er;
        logic [7:0] eh;
        logic [7:0] es;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 27;
    // status chained from reset: H=20 S=10 V=08 N=04 Z=02 C=01
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'h0F, 8'h01, 8'h00, 8'h10, 8'h00, 8'h20, 8'd2},  // R2 half carry
        '{4'd0,  8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'h23, 8'd2},  // R2 carry, zero
        '{4'd1,  8'h10, 8'h20, 8'h00, 8'h31, 8'h00, 8'h00, 8'd2},  // R2 carry in
        '{4'd0,  8'h7F, 8'h01, 8'h00, 8'h80, 8'h00, 8'h2C, 8'd2},  // R2 overflow
        '{4'd2,  8'h10, 8'h01, 8'h00, 8'h0F, 8'h00, 8'h20, 8'd3},  // R3 half borrow
        '{4'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 8'h00, 8'h35, 8'd3},  // R3 borrow
        '{4'd3,  8'h05, 8'h02, 8'h00, 8'h02, 8'h00, 8'h00, 8'd3},  // R3 borrow in
        '{4'd2,  8'h80, 8'h01, 8'h00, 8'h7F, 8'h00, 8'h38, 8'd3},  // R3 overflow
        '{4'd4,  8'hF0, 8'h3C, 8'h00, 8'h30, 8'h00, 8'h20, 8'd4},  // R4 and
        '{4'd5,  8'h80, 8'h01, 8'h00, 8'h81, 8'h00, 8'h34, 8'd4},  // R4 or
        '{4'd6,  8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h22, 8'd4},  // R4 xor
        '{4'd12, 8'hFF, 8'h0F, 8'h00, 8'hF0, 8'h00, 8'h34, 8'd4},  // R4 clear bits
        '{4'd9,  8'h55, 8'h00, 8'h00, 8'hAA, 8'h00, 8'h35, 8'd6},  // R6 complement
        '{4'd7,  8'h7F, 8'h00, 8'h00, 8'h80, 8'h00, 8'h2D, 8'd5},  // R5 inc overflow
        '{4'd8,  8'h80, 8'h00, 8'h00, 8'h7F, 8'h00, 8'h39, 8'd5},  // R5 dec overflow
        '{4'd8,  8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h23, 8'd5},  // R5 dec to zero
        '{4'd10, 8'h01, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h35, 8'd3},  // R3 negate
        '{4'd10, 8'h80, 8'h00, 8'h00, 8'h80, 8'h00, 8'h0D, 8'd3},  // R3 negate 0x80
        '{4'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'd3},  // R3 negate zero
        '{4'd11, 8'h12, 8'h34, 8'h00, 8'hFF, 8'h00, 8'h02, 8'd7},  // R7 set all
        '{4'd15, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h02, 8'd7},  // R7 pass
        '{4'd0,  8'h08, 8'h08, 8'h00, 8'h10, 8'h00, 8'h20, 8'd2},  // R2 sets H again
        '{4'd13, 8'hFF, 8'h01, 8'h12, 8'h00, 8'h13, 8'h20, 8'd10}, // R10 ripple
        '{4'd13, 8'hFF, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h23, 8'd10}, // R10 wrap
        '{4'd14, 8'h00, 8'h01, 8'h80, 8'hFF, 8'h7F, 8'h38, 8'd10}, // R10 overflow
        '{4'd13, 8'hC0, 8'hFF, 8'h7F, 8'hFF, 8'h7F, 8'h20, 8'd10}, // R10 imm truncated
        '{4'd14, 8'h00, 8'h05, 8'h00, 8'hFB, 8'hFF, 8'h35, 8'd10}  // R10 borrow
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // returns after the result is visible
    task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] h);
        @(negedge clk);
        issue = 1'b1; opcode = o; src_a = a; src_b = b; pair_hi = h;
        @(negedge clk);
        issue = 1'b0;
        if (o == 4'd13 || o == 4'd14) begin
            check8("R10 busy during second cycle", {6'd0, busy, done}, 8'h02);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check8("R1 status in reset", status, 8'h00);
        check8("R1 result in reset", result, 8'h00);
        check8("R1 done/busy in reset", {6'd0, done, busy}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1 status after release", status, 8'h00);
        check8("R1 result_hi after release", result_hi, 8'h00);

        for (int i = 0; i < NV; i++) begin
            string tg;
            run_op(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].hi);
            tg = $sformatf("R%0d vector %0d", VECS[i].req, i);
            check8({tg, " result"}, result, VECS[i].er);
            check8({tg, " result_hi"}, result_hi, VECS[i].eh);
            check8({tg, " status"}, status, VECS[i].es);
            check8({tg, " done"}, {7'd0, done}, 8'h01);
        end

        // R11: request during busy is dropped; 0x4010 + 5 = 0x4015, flags clear, H kept
        @(negedge clk);
        issue = 1'b1; opcode = 4'd13; src_a = 8'h10; src_b = 8'h05; pair_hi = 8'h40;
        @(negedge clk);
        check8("R11 busy seen", {7'd0, busy}, 8'h01);
        opcode = 4'd0; src_a = 8'hFF; src_b = 8'h01; // would set Z and C
        @(negedge clk);
        issue = 1'b0;
        check8("R11 word low byte", result, 8'h15);
        check8("R11 word high byte", result_hi, 8'h40);
        check8("R11 status after word", status, 8'h20);
        @(negedge clk);
        check8("R11 no extra done", {6'd0, done, busy}, 8'h00);
        check8("R11 status unchanged by dropped add", status, 8'h20);
        check8("R11 result unchanged by dropped add", result, 8'h15);

        // R12: byte op clears result_hi, done pulses once, result holds
        run_op(4'd0, 8'h01, 8'h01, 8'h00);
        check8("R12 result", result, 8'h02);
        check8("R12 result_hi cleared", result_hi, 8'h00);
        check8("R12 status", status, 8'h00);
        @(negedge clk);
        check8("R12 done drops", {7'd0, done}, 8'h00);
        check8("R12 result held", result, 8'h02);

        // R9: top status bits stay zero through a full flag set
        run_op(4'd2, 8'h00, 8'h01, 8'h00);
        check8("R9 top bits", {status[7:6], 6'd0}, 8'h00);
        check8("R8 sign equals N xor V", {7'd0, status[4]}, {7'd0, status[2] ^ status[3]});

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check8("R1 status after second reset", status, 8'h00);
        check8("R1 result after second reset", result, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        report();
    end

endmodule